// File: doc/BRIEF.md
# Wiper Register Bank with Nonvolatile Commit

This block is the register file and persistence controller that sits behind a serial front end in a dual digital potentiometer. It keeps a volatile wiper code for each of two potentiometers, a nonvolatile initial code for each, five nonvolatile general-purpose bytes and a small control register. A single address reaches either the volatile wiper or its nonvolatile initial value, and a mode bit in the control register selects which. The front end delivers decoded register writes as a one-cycle strobe with address and data. It presents a read address and takes the read data back combinationally. When chip select rises it sends a one-cycle end-of-frame pulse.

The nonvolatile cells sit outside the block, behind a simple array port: an address, write data, a write enable and combinational read data. After power becomes good, the block copies the whole array into local shadow copies, and each wiper is loaded from its initial value. A nonvolatile write is only staged while the frame is open. Its single array write starts after the frame ends. A busy flag then stays high for a fixed, parameterised number of cycles, and it blocks every register write during that time. Shutdown comes from a pin or from a control bit. During shutdown both wiper outputs are driven to the low-end code, and the stored codes are kept.

Top module: `wiper_bank`

## Requirements
- R1: While `pwr_good` is low (after it has been low for two clock edges), both wipers hold code 40h, and the control register reads 60h: mode 0, run 1, busy 1.
- R2: After `pwr_good` rises, within 16 cycles, every nonvolatile byte reads back the array contents and each wiper holds the low 7 bits of its initial value.
- R3: With the mode bit (control bit 7) at 1, writes to address 0 or 1 change only that wiper, reads of 0 or 1 return {0, wiper}, and the nonvolatile array is not written.
- R4: With the mode bit at 0, a write to address 0 or 1 updates the initial value and copies data[6:0] into the wiper on the next cycle. The array entry is written only after the frame ends.
- R5: With the mode bit at 0, reading address 0 or 1 returns the initial value and leaves the wiper code unchanged.
- R6: An end-of-frame pulse with a staged nonvolatile write produces exactly one array write cycle. The busy bit (control bit 5) then reads 1 for `NV_WRITE_CYCLES` cycles after the pulse edge and 0 on the cycle after. An end of frame with nothing staged leaves busy at 0.
- R7: While busy is 1, writes to any address (wipers, initial values, general-purpose bytes, control register) have no effect.
- R8: Only the first nonvolatile-targeted write in a frame is kept. Later nonvolatile-targeted writes in the same frame are dropped, including their wiper copy.
- R9: Shutdown is active when `shdn_n_pin` is low or control bit 6 is 0. Shutdown drives both wiper outputs to 0 and `shdn_out` to 1. Registers stay writable, and the stored code reappears when shutdown ends.
- R10: Addresses 2 to 6 are general-purpose nonvolatile bytes when the mode bit is 0. When it is 1 they read 0 and ignore writes. Addresses 7 and 9 to 15 always read 0 and ignore writes.
- R11: The control register sits at address 8. Bit 7 is the mode bit (reset 0), bit 6 is run (reset 1), bit 5 is busy (read only; a written value is ignored), and bits 4:0 read 0.
- R12: Bit 7 of data written to a wiper, or recalled into a wiper, is ignored. The wiper outputs are 7 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Combinational read data |
| frame_end | input | 1 | One-cycle pulse when chip select rises |
| pwr_good | input | 1 | Supply high enough for array recall |
| shdn_n_pin | input | 1 | Active-low shutdown pin |
| nv_we | output | 1 | Array write enable |
| nv_addr | output | 4 | Array address (recall index or staged address) |
| nv_wdata | output | 8 | Array write data |
| nv_rdata | input | 8 | Array read data for `nv_addr` |
| wiper0 | output | 7 | Potentiometer 0 tap code (0 in shutdown) |
| wiper1 | output | 7 | Potentiometer 1 tap code (0 in shutdown) |
| shdn_out | output | 1 | Shutdown active |

## Verification
Directed frames cover each mode-bit setting against addresses 0 and 1, which separates a volatile-only write from a write that also updates the initial value. They also cover the wiper-only effect of reads. Writes arrive in the cycles just after an end of frame, which shows whether the busy window blocks them and how long it lasts. A frame carrying two nonvolatile writes shows whether only the first one is committed. A power cycle recalls the committed values, which shows the array write really happened. Random frames with mixed addresses and data then exercise the whole decode against a bench model of the register map.

// File: rtl/wb_pkg.sv
package wb_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int WIPER_W   = 7;
    localparam int NUM_POTS  = 2;
    localparam int NV_REGS   = 7;
    localparam int NV_IDX_W  = $clog2(NV_REGS);
    localparam int GP_LAST   = NV_REGS - 1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd8;
    localparam logic [WIPER_W-1:0] WIPER_PARK = 7'h40;

    typedef enum logic [1:0] {
        SEQ_OFF,
        SEQ_RECALL,
        SEQ_READY,
        SEQ_COMMIT
    } seq_state_e;

    typedef struct packed {
        logic vol;  // 1: addresses 0/1 reach the wiper only
        logic run;  // 0: shutdown requested
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{vol: 1'b0, run: 1'b1};

    function automatic logic is_pot_addr(logic [ADDR_W-1:0] a);
        return a < ADDR_W'(NUM_POTS);
    endfunction

    function automatic logic is_gp_addr(logic [ADDR_W-1:0] a);
        return (a >= ADDR_W'(NUM_POTS)) && (a <= ADDR_W'(GP_LAST));
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_image(ctrl_t c, logic busy);
        return {c.vol, c.run, busy, 5'b0};
    endfunction

endpackage

// File: rtl/wb_seq.sv
module wb_seq
    import wb_pkg::*;
#(
    parameter int NV_WRITE_CYCLES = 2_500_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwr_good,
    input  logic                frame_end,
    input  logic                staged,
    output logic                rec_valid,
    output logic [NV_IDX_W-1:0] rec_idx,
    output logic                commit_we,
    output logic                busy,
    output logic                hold_defaults
);
    localparam int CNT_W = $clog2(NV_WRITE_CYCLES + 1);

    seq_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [NV_IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            state_q <= SEQ_OFF;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_OFF: begin
                    state_q <= SEQ_RECALL;
                    idx_q   <= '0;
                end
                SEQ_RECALL: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == NV_IDX_W'(NV_REGS - 1)) state_q <= SEQ_READY;
                end
                SEQ_READY: begin
                    if (frame_end && staged) begin
                        state_q <= SEQ_COMMIT;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(NV_WRITE_CYCLES - 1)) state_q <= SEQ_READY;
                end
            endcase
        end
    end

    assign rec_valid     = (state_q == SEQ_RECALL);
    assign rec_idx       = idx_q;
    assign commit_we     = (state_q == SEQ_COMMIT) && (cnt_q == '0);
    assign busy          = (state_q != SEQ_READY);
    assign hold_defaults = (state_q == SEQ_OFF);

endmodule

// File: rtl/wb_view.sv
module wb_view
    import wb_pkg::*;
(
    input  logic [NUM_POTS-1:0][WIPER_W-1:0] wr_i,
    input  logic [NV_REGS-1:0][DATA_W-1:0]   nvs_i,
    input  ctrl_t                            ctrl_i,
    input  logic                             busy,
    input  logic                             shdn_n_pin,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_POTS-1:0][WIPER_W-1:0] wiper_o,
    output logic                             shdn_o
);
    assign shdn_o = !shdn_n_pin || !ctrl_i.run;

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        assign wiper_o[p] = shdn_o ? '0 : wr_i[p];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data = ctrl_image(ctrl_i, busy);
        end else if (is_pot_addr(rd_addr)) begin
            for (int p = 0; p < NUM_POTS; p++) begin
                if (rd_addr == ADDR_W'(p))
                    rd_data = ctrl_i.vol ? {1'b0, wr_i[p]} : nvs_i[p];
            end
        end else if (is_gp_addr(rd_addr) && !ctrl_i.vol) begin
            rd_data = nvs_i[rd_addr[NV_IDX_W-1:0]];
        end
    end

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wb_pkg::*;
#(
    parameter int NV_WRITE_CYCLES = 2_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_end,
    input  logic              pwr_good,
    input  logic              shdn_n_pin,
    output logic              nv_we,
    output logic [ADDR_W-1:0] nv_addr,
    output logic [DATA_W-1:0] nv_wdata,
    input  logic [DATA_W-1:0] nv_rdata,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1,
    output logic              shdn_out
);
    logic [NUM_POTS-1:0][WIPER_W-1:0] wr_q;
    logic [NV_REGS-1:0][DATA_W-1:0]   nvs_q;
    ctrl_t                            ctrl_q;
    logic                             staged_q;
    logic [NV_IDX_W-1:0]              stage_addr_q;
    logic [DATA_W-1:0]                stage_data_q;

    logic                             rec_valid, commit_we, busy, hold_defaults;
    logic [NV_IDX_W-1:0]              rec_idx;
    logic [NUM_POTS-1:0][WIPER_W-1:0] wiper_vec;
    logic                             wr_ok, nv_free;

    wb_seq #(.NV_WRITE_CYCLES(NV_WRITE_CYCLES)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .pwr_good      (pwr_good),
        .frame_end     (frame_end),
        .staged        (staged_q),
        .rec_valid     (rec_valid),
        .rec_idx       (rec_idx),
        .commit_we     (commit_we),
        .busy          (busy),
        .hold_defaults (hold_defaults)
    );

    assign wr_ok   = wr_en && !busy;
    assign nv_free = !ctrl_q.vol && !staged_q && !frame_end;

    always_ff @(posedge clk) begin
        if (rst || hold_defaults) begin
            wr_q         <= {NUM_POTS{WIPER_PARK}};
            nvs_q        <= '0;
            ctrl_q       <= CTRL_DEFAULT;
            staged_q     <= 1'b0;
            stage_addr_q <= '0;
            stage_data_q <= '0;
        end else if (rec_valid) begin
            nvs_q[rec_idx] <= nv_rdata;
            for (int p = 0; p < NUM_POTS; p++) begin
                if (rec_idx == NV_IDX_W'(p)) wr_q[p] <= nv_rdata[WIPER_W-1:0];
            end
        end else begin
            if (frame_end) staged_q <= 1'b0;
            if (wr_ok) begin
                if (wr_addr == ADDR_CTRL) begin
                    ctrl_q <= '{vol: wr_data[7], run: wr_data[6]};
                end else if (is_pot_addr(wr_addr)) begin
                    for (int p = 0; p < NUM_POTS; p++) begin
                        if (wr_addr == ADDR_W'(p)) begin
                            if (ctrl_q.vol) begin
                                wr_q[p] <= wr_data[WIPER_W-1:0];
                            end else if (nv_free) begin
                                wr_q[p]      <= wr_data[WIPER_W-1:0];
                                nvs_q[p]     <= wr_data;
                                staged_q     <= 1'b1;
                                stage_addr_q <= NV_IDX_W'(p);
                                stage_data_q <= wr_data;
                            end
                        end
                    end
                end else if (is_gp_addr(wr_addr) && nv_free) begin
                    nvs_q[wr_addr[NV_IDX_W-1:0]] <= wr_data;
                    staged_q     <= 1'b1;
                    stage_addr_q <= wr_addr[NV_IDX_W-1:0];
                    stage_data_q <= wr_data;
                end
            end
        end
    end

    wb_view u_view (
        .wr_i       (wr_q),
        .nvs_i      (nvs_q),
        .ctrl_i     (ctrl_q),
        .busy       (busy),
        .shdn_n_pin (shdn_n_pin),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wiper_o    (wiper_vec),
        .shdn_o     (shdn_out)
    );

    assign wiper0   = wiper_vec[0];
    assign wiper1   = wiper_vec[1];
    assign nv_we    = commit_we;
    assign nv_addr  = rec_valid ? {{(ADDR_W-NV_IDX_W){1'b0}}, rec_idx}
                                : {{(ADDR_W-NV_IDX_W){1'b0}}, stage_addr_q};
    assign nv_wdata = stage_data_q;

endmodule

// File: rtl/wb_checker.sv
module wb_checker
    import wb_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic                             pwr_good,
    input logic                             shdn_n_pin,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                rd_addr,
    input logic [DATA_W-1:0]                rd_data,
    input logic                             nv_we,
    input logic [WIPER_W-1:0]               wiper0,
    input logic [WIPER_W-1:0]               wiper1,
    input logic                             shdn_out,
    input logic                             busy,
    input logic                             rec_valid,
    input logic [NUM_POTS-1:0][WIPER_W-1:0] wr_q,
    input logic [NV_REGS-1:0][DATA_W-1:0]   nvs_q,
    input ctrl_t                            ctrl_q
);
    assert_park_R1: assert property (@(posedge clk) disable iff (rst)
        (!pwr_good && $past(!pwr_good) && $past(!pwr_good, 2) && shdn_n_pin)
        |-> (wiper0 == WIPER_PARK && wiper1 == WIPER_PARK));

    assert_single_we_R6: assert property (@(posedge clk) disable iff (rst)
        nv_we |=> !nv_we);

    assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !rec_valid && pwr_good)
        |=> ($stable(wr_q) && $stable(nvs_q) && $stable(ctrl_q)));

    assert_pin_shdn_R9: assert property (@(posedge clk) disable iff (rst)
        !shdn_n_pin |-> (shdn_out && wiper0 == '0 && wiper1 == '0));

    assert_hole_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 4'd7) |-> (rd_data == '0));

    assert_ctrl_pad_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_CTRL) |-> (rd_data[4:0] == '0));

endmodule

bind wiper_bank wb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_good   (pwr_good),
    .shdn_n_pin (shdn_n_pin),
    .wr_en      (wr_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .nv_we      (nv_we),
    .wiper0     (wiper0),
    .wiper1     (wiper1),
    .shdn_out   (shdn_out),
    .busy       (busy),
    .rec_valid  (rec_valid),
    .wr_q       (wr_q),
    .nvs_q      (nvs_q),
    .ctrl_q     (ctrl_q)
);

// File: tb/tb_wiper_bank.sv
`timescale 1ns/1ps
module tb_wiper_bank;
    localparam int NVW = 37;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       frame_end = 1'b0;
    logic       pwr_good = 1'b0;
    logic       shdn_n_pin = 1'b1;
    logic       nv_we;
    logic [3:0] nv_addr;
    logic [7:0] nv_wdata;
    logic [7:0] nv_rdata;
    logic [6:0] wiper0, wiper1;
    logic       shdn_out;

    always #4 clk = ~clk;

    wiper_bank #(.NV_WRITE_CYCLES(NVW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_end(frame_end),
        .pwr_good(pwr_good), .shdn_n_pin(shdn_n_pin), .nv_we(nv_we),
        .nv_addr(nv_addr), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata),
        .wiper0(wiper0), .wiper1(wiper1), .shdn_out(shdn_out)
    );

    // External nonvolatile array model
    logic [7:0] mem [0:6];
    logic [7:0] pre_img [0:6];
    logic       pre_we = 1'b0;
    int         we_count = 0;
    always @(posedge clk) begin
        if (pre_we) begin
            for (int i = 0; i < 7; i++) mem[i] <= pre_img[i];
        end else if (nv_we && nv_addr < 4'd7) begin
            mem[nv_addr[2:0]] <= nv_wdata;
        end
        if (nv_we) we_count <= we_count + 1;
    end
    assign nv_rdata = (nv_addr < 4'd7) ? mem[nv_addr[2:0]] : 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the register map
    logic [6:0] m_wr [0:1];
    logic [7:0] m_nv [0:6];
    logic [7:0] m_mem [0:6];
    logic       m_vol, m_run, m_taken;
    logic [2:0] m_paddr;
    logic [7:0] m_pdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        if (a == 4'd8) begin
            m_vol = d[7];
            m_run = d[6];
        end else if (a < 4'd2) begin
            if (m_vol) m_wr[a[0]] = d[6:0];
            else if (!m_taken) begin
                m_nv[a[2:0]] = d; m_wr[a[0]] = d[6:0];
                m_taken = 1'b1; m_paddr = a[2:0]; m_pdata = d;
            end
        end else if (a <= 4'd6 && !m_vol && !m_taken) begin
            m_nv[a[2:0]] = d;
            m_taken = 1'b1; m_paddr = a[2:0]; m_pdata = d;
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a == 4'd8) return {m_vol, m_run, 6'b0};
        if (a < 4'd2) return m_vol ? {1'b0, m_wr[a[0]]} : m_nv[a[2:0]];
        if (a <= 4'd6) return m_vol ? 8'h00 : m_nv[a[2:0]];
        return 8'h00;
    endfunction

    function automatic logic [6:0] exp_wiper(input int p);
        return (!m_run || !shdn_n_pin) ? 7'h00 : m_wr[p];
    endfunction

    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input bit locked);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
        if (!locked) model_write(a, d);
    endtask

    task automatic pulse_frame_end();
        frame_end = 1'b1;
        tick();
        frame_end = 1'b0;
    endtask

    task automatic end_frame();
        pulse_frame_end();
        if (m_taken) m_mem[m_paddr] = m_pdata;
        m_taken = 1'b0;
        repeat (NVW + 2) tick();
    endtask

    task automatic model_recall();
        m_vol = 1'b0; m_run = 1'b1; m_taken = 1'b0;
        for (int i = 0; i < 7; i++) m_nv[i] = m_mem[i];
        m_wr[0] = m_mem[0][6:0];
        m_wr[1] = m_mem[1][6:0];
    endtask

    task automatic check_all(input string req);
        logic [7:0] d;
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), d);
            check(req, d, exp_read(4'(a)));
        end
        check(req, wiper0, exp_wiper(0));
        check(req, wiper1, exp_wiper(1));
        for (int i = 0; i < 7; i++) check(req, mem[i], m_mem[i]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int wc;
        void'($urandom(32'd20240611));
        pre_img[0] = 8'h95; pre_img[1] = 8'h23; pre_img[2] = 8'h11; pre_img[3] = 8'h22;
        pre_img[4] = 8'h33; pre_img[5] = 8'h44; pre_img[6] = 8'h55;
        for (int i = 0; i < 7; i++) m_mem[i] = pre_img[i];
        pre_we = 1'b1;
        repeat (3) tick();
        pre_we = 1'b0;
        rst = 1'b0;
        repeat (2) tick();

        // R1 / R11: powered-down state
        rd(4'd8, d);
        check("R11 ctrl while unpowered", d, 8'h60);
        check("R1 wiper0 parked", wiper0, 7'h40);
        check("R1 wiper1 parked", wiper1, 7'h40);

        // R2 / R12: recall
        pwr_good = 1'b1;
        repeat (16) tick();
        model_recall();
        check("R2 R12 wiper0 recalled", wiper0, 7'h15);
        check("R2 wiper1 recalled", wiper1, 7'h23);
        rd(4'd0, d);  check("R2 ivr0 readback", d, 8'h95);
        rd(4'd5, d);  check("R10 gp5 readback", d, 8'h44);
        rd(4'd8, d);  check("R11 ctrl ready", d, 8'h40);

        // R3 / R11 / R12 / R10: volatile mode
        do_write(4'd8, 8'hE0, 1'b0);
        rd(4'd8, d);  check("R11 busy bit not writable", d, 8'hC0);
        do_write(4'd0, 8'h8A, 1'b0);
        check("R12 R3 wiper0 from volatile write", wiper0, 7'h0A);
        rd(4'd0, d);  check("R3 volatile read", d, 8'h0A);
        do_write(4'd2, 8'h99, 1'b0);
        rd(4'd2, d);  check("R10 gp hidden in volatile mode", d, 8'h00);
        wc = we_count;
        pulse_frame_end();
        rd(4'd8, d);  check("R6 no busy without staged write", d, 8'hC0);
        repeat (NVW + 2) tick();
        check("R3 no array write", we_count, wc);
        check("R3 array entry 0 kept", mem[0], 8'h95);
        check("R10 gp2 array kept", mem[2], 8'h11);

        // R5: reading initial value leaves wiper
        do_write(4'd8, 8'h40, 1'b0);
        rd(4'd0, d);  check("R5 ivr0 read", d, 8'h95);
        check("R5 wiper0 unchanged", wiper0, 7'h0A);
        end_frame();

        // R4 / R6 / R7: nonvolatile write and busy window
        do_write(4'd1, 8'h7E, 1'b0);
        check("R4 wiper1 copy", wiper1, 7'h7E);
        check("R4 array not yet written", mem[1], 8'h23);
        wc = we_count;
        pulse_frame_end();
        m_mem[1] = 8'h7E; m_taken = 1'b0;
        rd(4'd8, d);  check("R6 busy after frame end", d, 8'h60);
        do_write(4'd8, 8'hC0, 1'b1);
        do_write(4'd0, 8'h01, 1'b1);
        do_write(4'd3, 8'h5A, 1'b1);
        rd(4'd8, d);  check("R7 ctrl write rejected", d, 8'h60);
        check("R7 wiper write rejected", wiper0, 7'h0A);
        rd(4'd3, d);  check("R7 gp write rejected", d, 8'h22);
        repeat (NVW - 4) tick();
        rd(4'd8, d);  check("R6 busy last cycle", d, 8'h60);
        tick();
        rd(4'd8, d);  check("R6 busy cleared", d, 8'h40);
        check("R6 one array write", we_count - wc, 1);
        check("R4 array entry 1 written", mem[1], 8'h7E);
        check_all("R4 map after commit");

        // R8: one commit per frame
        do_write(4'd3, 8'h66, 1'b0);
        do_write(4'd4, 8'h77, 1'b0);
        do_write(4'd1, 8'h05, 1'b0);
        check("R8 dropped write leaves wiper1", wiper1, 7'h7E);
        end_frame();
        check("R8 first commit", mem[3], 8'h66);
        check("R8 second dropped", mem[4], 8'h33);
        rd(4'd4, d);  check("R8 gp4 shadow", d, 8'h33);

        // R9: shutdown
        shdn_n_pin = 1'b0;
        tick();
        check("R9 pin shutdown wiper0", wiper0, 7'h00);
        check("R9 pin shutdown wiper1", wiper1, 7'h00);
        check("R9 pin shutdown flag", shdn_out, 1'b1);
        do_write(4'd8, 8'hC0, 1'b0);
        do_write(4'd0, 8'h55, 1'b0);
        shdn_n_pin = 1'b1;
        tick();
        check("R9 wiper0 after pin release", wiper0, 7'h55);
        check("R9 flag cleared", shdn_out, 1'b0);
        do_write(4'd8, 8'h80, 1'b0);
        check("R9 ctrl shutdown wiper0", wiper0, 7'h00);
        check("R9 ctrl shutdown flag", shdn_out, 1'b1);
        do_write(4'd8, 8'hC0, 1'b0);
        check("R9 wiper0 restored", wiper0, 7'h55);
        end_frame();

        // R10: holes
        rd(4'd7, d);  check("R10 addr7 zero", d, 8'h00);
        rd(4'd9, d);  check("R10 addr9 zero", d, 8'h00);
        rd(4'd15, d); check("R10 addr15 zero", d, 8'h00);
        do_write(4'd7, 8'hFF, 1'b0);
        rd(4'd7, d);  check("R10 addr7 write ignored", d, 8'h00);
        end_frame();

        // R1 / R2: power cycle recalls committed values
        pwr_good = 1'b0;
        repeat (2) tick();
        check("R1 wiper0 parked on power loss", wiper0, 7'h40);
        check("R1 wiper1 parked on power loss", wiper1, 7'h40);
        rd(4'd8, d);  check("R1 ctrl on power loss", d, 8'h60);
        pwr_good = 1'b1;
        repeat (16) tick();
        model_recall();
        check("R2 wiper0 after cycle", wiper0, 7'h15);
        check("R2 wiper1 after cycle", wiper1, 7'h7E);
        rd(4'd3, d);  check("R2 gp3 after cycle", d, 8'h66);

        // Random frames
        for (int f = 0; f < 60; f++) begin
            int n;
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) begin
                logic [3:0] a;
                logic [7:0] v;
                a = 4'($urandom % 10);
                v = 8'($urandom);
                if (a == 4'd8 && ($urandom % 4) != 0) v[6] = 1'b1;
                do_write(a, v, 1'b0);
            end
            end_frame();
            check_all("R10 R3 R4 R8 random frame");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule